// File: doc/BRIEF.md
# Inbound Requester-to-Partition Classifier

This block labels each inbound request arriving from the I/O fabric with the isolation partition that owns the requester. The request may be a DMA access, an MSI write or an error message. The partition number comes from a directly indexed table keyed by the 16-bit requester ID (bus, device, function). For DMA the block also names which of the partition's two address-space windows the access falls in. For MSI writes it works out an 11-bit interrupt index. It then authorises the write only if the partition stored in that interrupt's descriptor matches the requester's partition.

Both tables use synchronous RAM and are loaded through a simple write port. The result appears on the outputs one cycle after an accepted request. An MSI that fails the partition check is rejected. It also moves a two-state violation machine from CLEAN to TRIPPED, which records the offending requester ID. TRIPPED is left only by reset. The only transition is CLEAN to TRIPPED, taken on the first partition mismatch.

Top module: `req_part_classifier`

## Requirements
- R1: A request with `req_valid` high and `req_kind` not 2'b11 gives exactly one result, with `out_valid` high in the following cycle. Kind 2'b11 is reserved and gives no result. `out_ok` and `out_reject` are low whenever `out_valid` is low.
- R2: `out_part` equals the requester-table entry at index `req_rid[7:0]`, the low TBL_AW bits (8 by default). Two IDs that share those bits therefore map to the same partition. `out_kind` echoes the request kind: 2'b00 DMA, 2'b01 MSI, 2'b10 error.
- R3: For a DMA request (kind 2'b00), `out_win` equals address bit 59.
- R4: An MSI address hits the low window when address bits 63:16 equal 0x0000_0000_FFFF. It hits the high window when they equal 0x0001_0000_0000 (the default high base). The interrupt index is {window bit, data[9:0]}, where the window bit is 1 for the high window. An MSI that hits neither window reports index 0.
- R5: An MSI is authorised (`out_ok`=1) only when it hits a window and the descriptor entry at its interrupt index holds the requester's partition. Otherwise `out_reject`=1.
- R6: DMA and error results are always authorised. Error results report window 0 and index 0, and DMA results report index 0.
- R7: An MSI that hits a window but fails the partition check raises `viol_flag` two cycles after the request. The flag then stays high until reset. An MSI rejected for missing both windows leaves `viol_flag` unchanged.
- R8: `viol_rid` holds the full requester ID of the first mismatch. Later mismatches do not change it.
- R9: A write with `cfg_we`=1 stores `cfg_data` into the requester table at `cfg_addr[7:0]` when `cfg_tbl`=0, or into the descriptor table at `cfg_addr` when `cfg_tbl`=1. The new value is used by requests from the next cycle on.
- R10: After reset, `out_valid`, `out_ok`, `out_reject` and `viol_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 DMA, 01 MSI, 10 error, 11 reserved |
| req_rid | input | 16 | Requester ID |
| req_addr | input | 64 | Request address |
| req_data | input | 32 | MSI write data |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | 0 requester table, 1 descriptor table |
| cfg_addr | input | 11 | Table write index |
| cfg_data | input | 8 | Partition number to write |
| out_valid | output | 1 | Result present |
| out_kind | output | 2 | Kind of the classified request |
| out_part | output | 8 | Partition number of the requester |
| out_win | output | 1 | DMA window select |
| out_irq | output | 11 | MSI interrupt index |
| out_ok | output | 1 | Request authorised |
| out_reject | output | 1 | Request rejected |
| viol_flag | output | 1 | Sticky MSI partition violation |
| viol_rid | output | 16 | Requester ID of the first violation |

## Verification
A corrupted pipeline register shows up as a wrong partition, window or index in the very next result. The scoreboard compares every result field against a model built from the programmed tables, so such a fault is caught within one cycle of the request. A violation machine stuck in TRIPPED, or one that misses its trip, becomes visible on `viol_flag` two cycles after the MSI that should or should not trip it. A recorder that overwrites on later mismatches is exposed by a second, different offending requester.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [1:0] {
        KIND_DMA  = 2'b00,
        KIND_MSI  = 2'b01,
        KIND_ERR  = 2'b10,
        KIND_RSVD = 2'b11
    } req_kind_e;

    typedef enum logic {
        VIOL_CLEAN   = 1'b0,
        VIOL_TRIPPED = 1'b1
    } viol_state_e;
endpackage

// File: rtl/rpc_table.sv
module rpc_table #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem_q[rd_addr];
        end
    end
endmodule

// File: rtl/rpc_msi_decode.sv
module rpc_msi_decode #(
    parameter int                ADDR_W  = 64,
    parameter int                DATA_W  = 32,
    parameter int                IRQ_W   = 11,
    parameter int                WIN_LSB = 16,
    parameter logic [ADDR_W-1:0] LO_BASE = 64'h0000_0000_FFFF_0000,
    parameter logic [ADDR_W-1:0] HI_BASE = 64'h0001_0000_0000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit,
    output logic [IRQ_W-1:0]  irq
);
    logic lo_hit;
    logic hi_hit;
    logic unused_bits;

    assign lo_hit = (addr[ADDR_W-1:WIN_LSB] == LO_BASE[ADDR_W-1:WIN_LSB]);
    assign hi_hit = (addr[ADDR_W-1:WIN_LSB] == HI_BASE[ADDR_W-1:WIN_LSB]);
    assign hit    = lo_hit | hi_hit;
    assign irq    = hit ? {hi_hit, data[IRQ_W-2:0]} : '0;

    assign unused_bits = ^{addr[WIN_LSB-1:0], data[DATA_W-1:IRQ_W-1]};
endmodule

// File: rtl/rpc_viol_fsm.sv
module rpc_viol_fsm
    import rpc_pkg::*;
#(
    parameter int RID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip,
    input  logic [RID_W-1:0] trip_rid,
    output logic             flag,
    output logic [RID_W-1:0] rid
);
    viol_state_e state_q;
    viol_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VIOL_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VIOL_CLEAN:   if (trip) state_d = VIOL_TRIPPED;
            VIOL_TRIPPED: state_d = VIOL_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rid <= '0;
        end else if (state_q == VIOL_CLEAN && trip) begin
            rid <= trip_rid;
        end
    end

    assign flag = (state_q == VIOL_TRIPPED);

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag); // R7
    AST_VIOL_RID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VIOL_TRIPPED) |=> $stable(rid)); // R8
endmodule

// File: rtl/req_part_classifier.sv
module req_part_classifier
    import rpc_pkg::*;
#(
    parameter int                RID_W   = 16,
    parameter int                TBL_AW  = 8,
    parameter int                PE_W    = 8,
    parameter int                IRQ_W   = 11,
    parameter int                ADDR_W  = 64,
    parameter int                DATA_W  = 32,
    parameter int                WIN_BIT = 59,
    parameter int                WIN_LSB = 16,
    parameter logic [ADDR_W-1:0] MSI_LO_BASE = 64'h0000_0000_FFFF_0000,
    parameter logic [ADDR_W-1:0] MSI_HI_BASE = 64'h0001_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [IRQ_W-1:0]  cfg_addr,
    input  logic [PE_W-1:0]   cfg_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [PE_W-1:0]   out_part,
    output logic              out_win,
    output logic [IRQ_W-1:0]  out_irq,
    output logic              out_ok,
    output logic              out_reject,
    output logic              viol_flag,
    output logic [RID_W-1:0]  viol_rid
);
    req_kind_e        kind_in;
    logic             accept;
    logic             msi_hit;
    logic [IRQ_W-1:0] msi_irq;
    logic [PE_W-1:0]  pe_rd;
    logic [PE_W-1:0]  desc_rd;

    logic             valid_q;
    req_kind_e        kind_q;
    logic             win_q;
    logic             hit_q;
    logic [IRQ_W-1:0] irq_q;
    logic [RID_W-1:0] rid_q;

    logic             auth;
    logic             trip;
    logic             unused_rid_hi;

    assign kind_in = req_kind_e'(req_kind);
    assign accept  = req_valid && (kind_in != KIND_RSVD);

    rpc_msi_decode #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .IRQ_W (IRQ_W),
        .WIN_LSB(WIN_LSB), .LO_BASE(MSI_LO_BASE), .HI_BASE(MSI_HI_BASE)
    ) u_decode (
        .addr(req_addr), .data(req_data), .hit(msi_hit), .irq(msi_irq)
    );

    rpc_table #(.AW(TBL_AW), .DW(PE_W)) u_rid_tbl (
        .clk    (clk),
        .wr_en  (cfg_we && !cfg_tbl),
        .wr_addr(cfg_addr[TBL_AW-1:0]),
        .wr_data(cfg_data),
        .rd_en  (accept),
        .rd_addr(req_rid[TBL_AW-1:0]),
        .rd_data(pe_rd)
    );

    rpc_table #(.AW(IRQ_W), .DW(PE_W)) u_desc_tbl (
        .clk    (clk),
        .wr_en  (cfg_we && cfg_tbl),
        .wr_addr(cfg_addr),
        .wr_data(cfg_data),
        .rd_en  (accept),
        .rd_addr(msi_irq),
        .rd_data(desc_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= KIND_DMA;
            win_q   <= 1'b0;
            hit_q   <= 1'b0;
            irq_q   <= '0;
            rid_q   <= '0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                kind_q <= kind_in;
                win_q  <= req_addr[WIN_BIT];
                hit_q  <= msi_hit;
                irq_q  <= msi_irq;
                rid_q  <= req_rid;
            end
        end
    end

    always_comb begin
        out_win = 1'b0;
        out_irq = '0;
        auth    = 1'b1;
        unique case (kind_q)
            KIND_DMA:  out_win = win_q;
            KIND_MSI: begin
                out_irq = irq_q;
                auth    = hit_q && (desc_rd == pe_rd);
            end
            KIND_ERR:  auth = 1'b1;
            KIND_RSVD: auth = 1'b0;
        endcase
    end

    assign out_valid  = valid_q;
    assign out_kind   = kind_q;
    assign out_part   = pe_rd;
    assign out_ok     = valid_q && auth;
    assign out_reject = valid_q && !auth;
    assign trip       = valid_q && (kind_q == KIND_MSI) && hit_q && (desc_rd != pe_rd);

    rpc_viol_fsm #(.RID_W(RID_W)) u_viol (
        .clk(clk), .rst_n(rst_n), .trip(trip), .trip_rid(rid_q),
        .flag(viol_flag), .rid(viol_rid)
    );

    assign unused_rid_hi = ^req_rid[RID_W-1:TBL_AW];

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'b11) |=> out_valid); // R1
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_kind == 2'b11) |=> !out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ok && !out_reject)); // R1
    AST_DMA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b00) |-> (out_win == $past(req_addr[WIN_BIT]))); // R3
    AST_NON_MSI_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'b01) |-> out_ok); // R6
endmodule

// File: tb/req_part_classifier_bench.sv
module req_part_classifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_rid = '0;
    logic [63:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_tbl = 1'b0;
    logic [10:0] cfg_addr = '0;
    logic [7:0]  cfg_data = '0;
    logic        out_valid, out_win, out_ok, out_reject, viol_flag;
    logic [1:0]  out_kind;
    logic [7:0]  out_part;
    logic [10:0] out_irq;
    logic [15:0] viol_rid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  kind;
        logic [7:0]  part;
        logic        win;
        logic [10:0] irq;
        logic        ok;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic [7:0] m_rid [256];
    logic [7:0] m_desc [2048];

    always #4 clk = ~clk;

    req_part_classifier u_req_part_classifier (
        .clk, .rst_n, .req_valid, .req_kind, .req_rid, .req_addr, .req_data,
        .cfg_we, .cfg_tbl, .cfg_addr, .cfg_data,
        .out_valid, .out_kind, .out_part, .out_win, .out_irq, .out_ok,
        .out_reject, .viol_flag, .viol_rid
    );

    task automatic check(input bit cond, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input bit tbl, input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tbl = tbl; cfg_addr = a; cfg_data = d;
        if (tbl) m_desc[a] = d; else m_rid[a[7:0]] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [1:0] k, input logic [15:0] rid,
                        input logic [63:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        logic lo, hi;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_rid = rid; req_addr = a; req_data = d;
        if (k != 2'b11) begin
            lo = (a[63:16] == 48'h0000_0000_FFFF);
            hi = (a[63:16] == 48'h0001_0000_0000);
            e.kind = k;
            e.part = m_rid[rid[7:0]];
            e.win  = (k == 2'b00) ? a[59] : 1'b0;
            e.irq  = (k == 2'b01 && (lo || hi)) ? {hi, d[9:0]} : 11'd0;
            e.ok   = (k != 2'b01) ? 1'b1 : ((lo || hi) && m_desc[e.irq] == e.part);
            e.tag  = tag;
            sb_q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1", "unexpected result", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(out_kind == e.kind, "R2", "kind", 64'(out_kind), 64'(e.kind));
                check(out_part == e.part && out_win == e.win && out_irq == e.irq &&
                      out_ok == e.ok && out_reject == !e.ok, e.tag, "part/win/irq/ok",
                      {out_part, 3'b0, out_win, 1'b0, out_irq, 3'b0, out_ok},
                      {e.part, 3'b0, e.win, 1'b0, e.irq, 3'b0, e.ok});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_ok && !out_reject, "R10", "outputs after reset",
              {out_valid, out_ok, out_reject}, 64'd0);
        check(!viol_flag, "R10", "viol_flag after reset", 64'(viol_flag), 64'd0);

        // R9: load the tables through the write port
        cfg_write(1'b0, 11'h012, 8'h05);
        cfg_write(1'b0, 11'h034, 8'h21);
        cfg_write(1'b0, 11'h0FF, 8'hA0);
        cfg_write(1'b1, 11'h005, 8'h05);
        cfg_write(1'b1, 11'h405, 8'h21);
        cfg_write(1'b1, 11'h3FF, 8'h77);

        send(2'b00, 16'h0012, 64'h0800_0000_0000_1000, 32'h0, "R3");
        send(2'b00, 16'h0134, 64'h0000_0000_2000_0000, 32'h0, "R3");
        send(2'b00, 16'h0034, 64'h0800_0000_0000_0000, 32'h0, "R2");
        send(2'b10, 16'h00FF, 64'h0800_0000_0000_0000, 32'h0, "R6");
        send(2'b11, 16'h0012, 64'h0, 32'h0, "R1");
        idle(1);
        check(!out_valid, "R1", "reserved kind gave a result", 64'(out_valid), 64'd0);

        send(2'b01, 16'h0012, 64'h0000_0000_FFFF_0100, 32'h1234_5405, "R4");
        send(2'b01, 16'h0134, 64'h0001_0000_0000_0040, 32'h0000_0005, "R5");
        send(2'b01, 16'h0012, 64'h0000_0000_FFFE_0000, 32'h0000_0005, "R5");
        idle(3);
        check(!viol_flag, "R7", "flag after window miss", 64'(viol_flag), 64'd0);

        send(2'b01, 16'h01FF, 64'h0000_0000_FFFF_0000, 32'h0000_03FF, "R5");
        idle(1);
        check(!viol_flag, "R7", "flag before trip latency", 64'(viol_flag), 64'd0);
        @(negedge clk);
        check(viol_flag, "R7", "flag after mismatch", 64'(viol_flag), 64'd1);
        check(viol_rid == 16'h01FF, "R8", "first violator", 64'(viol_rid), 64'h01FF);

        send(2'b01, 16'h0012, 64'h0001_0000_0000_0000, 32'h0000_0005, "R5");
        idle(3);
        check(viol_flag, "R7", "flag stays set", 64'(viol_flag), 64'd1);
        check(viol_rid == 16'h01FF, "R8", "violator kept", 64'(viol_rid), 64'h01FF);

        cfg_write(1'b0, 11'h012, 8'h21);
        send(2'b01, 16'h0012, 64'h0001_0000_0000_0000, 32'h0000_0005, "R9");
        send(2'b10, 16'h0112, 64'h0, 32'h0, "R9");
        idle(3);
        check(sb_q.size() == 0, "R1", "results outstanding", 64'(sb_q.size()), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule